// File: doc/BRIEF.md
# Registered ROM Read Port

This block is the read path of a 32K x 8 read-only memory. An address enters through an optional address-capture stage. It selects a word from a fixed array, and the word is loaded into an 8-bit output register on every rising clock edge. The data pins always show that register, never the array output directly. An active-low output-enable input controls the three-state data pins. It acts either immediately or through a copy sampled on the clock.

Three build-time parameters shape the read path. The first chooses between a flow-through address and a level-sensitive address latch. The second sets the level at which the latch-enable input opens the latch. The third chooses between an immediate enable and a clock-sampled enable. The array content is a fixed function of the address. A system uses the block as a lookup table whose outputs can share a bus with other drivers.

Top module: `rom_read_port`

## Requirements
- R1: With the output driven, `dq` shows the word at the address presented at the previous rising edge. Word k is the low 8 bits of (k XOR (k >> 8)), and the address is 15 bits wide.
- R2: Between rising edges, `dq` keeps the registered word even when the address changes.
- R3: A rising edge with `rst_n` low clears the output register to 0x00. In clocked-enable mode it also puts the outputs in high impedance (`dq_oe` = 0) until an edge samples `oe_n` low.
- R4: With `SYNC_OE` = 0, `dq_oe` equals the inverse of `oe_n` at all times, and no clock edge is involved.
- R5: With `SYNC_OE` = 1, `oe_n` is sampled on each rising edge. `dq_oe` takes the inverse of the sampled value and holds it until the next edge.
- R6: With `LATCH_ON` = 0, `ale` has no effect, and the address flows straight to the array.
- R7: With `LATCH_ON` = 1, the latch passes `addr` while `ale` is at its active level. It keeps the last address seen once `ale` leaves that level, and later address changes have no effect.
- R8: `ALE_HIGH` = 1 makes `ale` active high, and `ALE_HIGH` = 0 makes it active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register and the sampled enable |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 15 | Word address |
| ale | input | 1 | Address latch enable, polarity set by `ALE_HIGH` |
| oe_n | input | 1 | Active-low output enable |
| dq | output | 8 | Three-state data output |
| dq_oe | output | 1 | High while `dq` is driven |

## Verification
The bench builds all eight parameter combinations. It changes the address just after the latch closes. A latch that stayed transparent, or a polarity that was inverted, would then load the new word instead of the held one. It also changes the address and the enable between clock edges. A design that bypassed the output register would show the new word at once. A clocked enable that leaked through combinationally would switch `dq_oe` before the edge, and an immediate enable that waited for the clock would switch it late. Reading the top address 0x7FFF and a value with nonzero upper bits catches a truncated address or a wrong fill function.

// File: rtl/rom_pkg.sv
// Package rom_pkg
// Shared constants for the ROM read port. It holds the fill-function shift
// and names for the two build-time mode choices. It assumes no clocking.
package rom_pkg;
    // The right shift applied to the address in the fill function.
    localparam int FILL_SHIFT = 8;

    // Enable handling chosen at build time.
    typedef enum logic {
        OE_IMMEDIATE = 1'b0,
        OE_CLOCKED   = 1'b1
    } oe_mode_e;

    // Address path chosen at build time.
    typedef enum logic {
        ADDR_FLOW    = 1'b0,
        ADDR_LATCHED = 1'b1
    } addr_mode_e;
endpackage

// File: rtl/addr_capture.sv
// Module addr_capture
// Address entry stage. When LATCH_ON is set, a level-sensitive latch is open
// while ale sits at its active level (ALE_HIGH) and holds the address once
// ale leaves that level. Otherwise the address is passed straight through
// and ale is ignored. It assumes ale is glitch-free while addr changes.
module addr_capture
    import rom_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter bit LATCH_ON = 1'b0,
    parameter bit ALE_HIGH = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ale,
    output logic [ADDR_W-1:0] addr_out
);
    localparam addr_mode_e MODE = LATCH_ON ? ADDR_LATCHED : ADDR_FLOW;

    generate
        if (MODE == ADDR_LATCHED) begin : g_latch
            logic              open_w;
            logic [ADDR_W-1:0] held_q;

            assign open_w = (ale == ALE_HIGH);

            // Transparent latch: follows addr while open and keeps its value when closed.
            always_latch begin
                if (open_w) begin
                    held_q <= addr_in;
                end
            end

            assign addr_out = held_q;
        end else begin : g_flow
            logic unused_ale;

            // ale plays no part in flow-through mode.
            assign unused_ale = ale;
            assign addr_out   = addr_in;
        end
    endgenerate
endmodule

// File: rtl/rom_array.sv
// Module rom_array
// Combinational read-only array. Each word is computed from its address as
// the low DATA_W bits of (addr XOR (addr >> FILL_SHIFT)). It assumes
// ADDR_W > DATA_W.
module rom_array
    import rom_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic [ADDR_W-1:0] mixed_w;
    logic              unused_hi;

    // Fill pattern evaluated for the selected word.
    always_comb begin
        mixed_w = addr ^ (addr >> FILL_SHIFT);
    end

    assign data      = mixed_w[DATA_W-1:0];
    assign unused_hi = ^mixed_w[ADDR_W-1:DATA_W];
endmodule

// File: rtl/out_stage.sv
// Module out_stage
// Output register and enable control. Read data is registered on every
// rising edge. The active-low enable drives the output-valid flag either
// directly (SYNC_OE = 0) or through a copy sampled on the clock
// (SYNC_OE = 1). It assumes a synchronous active-low reset.
module out_stage
    import rom_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit SYNC_OE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              oe_n,
    output logic [DATA_W-1:0] data_q,
    output logic              drive
);
    localparam oe_mode_e MODE = SYNC_OE ? OE_CLOCKED : OE_IMMEDIATE;

    // Edge-triggered output register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= rd_data;
        end
    end

    generate
        if (MODE == OE_CLOCKED) begin : g_clocked
            logic oe_n_q;

            // Sampled enable; reset leaves the outputs disabled.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    oe_n_q <= 1'b1;
                end else begin
                    oe_n_q <= oe_n;
                end
            end

            assign drive = !oe_n_q;
        end else begin : g_immediate
            assign drive = !oe_n;
        end
    endgenerate
endmodule

// File: rtl/rom_read_port.sv
// Module rom_read_port
// Top of the registered ROM read path: address capture, computed array,
// output register and three-state output. The build-time parameters select
// the latch, its polarity and the enable mode. It assumes one clock domain
// and a synchronous active-low reset.
module rom_read_port #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter bit SYNC_OE  = 1'b0,
    parameter bit LATCH_ON = 1'b0,
    parameter bit ALE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ale,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq,
    output logic              dq_oe
);
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] data_q;

    addr_capture #(
        .ADDR_W  (ADDR_W),
        .LATCH_ON(LATCH_ON),
        .ALE_HIGH(ALE_HIGH)
    ) u_addr (
        .addr_in (addr),
        .ale     (ale),
        .addr_out(word_addr)
    );

    rom_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .addr(word_addr),
        .data(rd_data)
    );

    out_stage #(
        .DATA_W (DATA_W),
        .SYNC_OE(SYNC_OE)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_data(rd_data),
        .oe_n   (oe_n),
        .data_q (data_q),
        .drive  (dq_oe)
    );

    // Three-state pins show the register only while driven.
    assign dq = dq_oe ? data_q : {DATA_W{1'bz}};
endmodule

// File: rtl/rom_read_port_chk.sv
// Module rom_read_port_chk
// Property checker for rom_read_port, attached through bind. It watches the
// ports together with the internal word address and the output register.
module rom_read_port_chk #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter bit SYNC_OE  = 1'b0,
    parameter bit LATCH_ON = 1'b0,
    parameter bit ALE_HIGH = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ale,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [ADDR_W-1:0] word_addr,
    input logic [DATA_W-1:0] data_q
);
    function automatic logic [DATA_W-1:0] expect_word(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] t;
        t = a ^ (a >> 8);
        return t[DATA_W-1:0];
    endfunction

    logic ale_closed;
    assign ale_closed = (ale != ALE_HIGH);

    // The register loads the word at the address seen one edge earlier.
    assert_read_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (data_q == expect_word($past(word_addr))));

    // The edge that ends reset finds the register cleared.
    assert_reset_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (data_q == '0));

    // In clocked mode, reset leaves the outputs undriven.
    assert_reset_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (SYNC_OE && $rose(rst_n)) |-> !dq_oe);

    // Immediate enable follows the pin.
    assert_async_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !SYNC_OE |-> (dq_oe == !oe_n));

    // Clocked enable reflects the value sampled at the previous edge.
    assert_sync_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (SYNC_OE && rst_n) |=> (dq_oe == !$past(oe_n)));

    // Without the latch the array sees the pin address.
    assert_flow_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !LATCH_ON |-> (word_addr == addr));

    // A closed latch keeps its address (R8 sets the closed level).
    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (LATCH_ON && ale_closed && $past(ale_closed)) |-> $stable(word_addr));
endmodule

bind rom_read_port rom_read_port_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SYNC_OE (SYNC_OE),
    .LATCH_ON(LATCH_ON),
    .ALE_HIGH(ALE_HIGH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ale      (ale),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .word_addr(word_addr),
    .data_q   (data_q)
);

// File: tb/rom_cfg_bench.sv
// Directed scenarios for one parameter combination of rom_read_port.
module rom_cfg_bench #(
    parameter bit SYNC_OE  = 1'b0,
    parameter bit LATCH_ON = 1'b0,
    parameter bit ALE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic done
);
    logic [14:0] addr;
    logic        ale;
    logic        oe_n;
    wire  [7:0]  dq;
    logic        dq_oe;

    localparam logic ACT   = ALE_HIGH;
    localparam logic INACT = !ALE_HIGH;

    rom_read_port #(
        .SYNC_OE (SYNC_OE),
        .LATCH_ON(LATCH_ON),
        .ALE_HIGH(ALE_HIGH)
    ) u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .ale  (ale),
        .oe_n (oe_n),
        .dq   (dq),
        .dq_oe(dq_oe)
    );

    function automatic logic [7:0] exp_word(input logic [14:0] k);
        return k[7:0] ^ {1'b0, k[14:8]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cfg sync=%0d latch=%0d alehigh=%0d actual=%h expected=%h",
                     req, SYNC_OE, LATCH_ON, ALE_HIGH, act, exp);
        end
    endtask

    // Drive an address with the latch open, then check the data after one edge.
    task automatic read_at(input logic [14:0] a, input string req);
        addr = a;
        ale  = ACT;
        @(negedge clk);
        check(req, {7'd0, dq_oe}, 8'd1);
        check(req, dq, exp_word(a));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R3 oe during reset", {7'd0, dq_oe}, SYNC_OE ? 8'd0 : 8'd1);
        if (!SYNC_OE) check("R3 cleared register", dq, 8'h00);
        wait (rst_n);
        @(negedge clk);
    endtask

    task automatic t_reads();
        read_at(15'h0000, "R1 addr 0");
        read_at(15'h7FFF, "R1 top addr");
        read_at(15'h1234, "R1 mixed addr");
        read_at(15'h00FF, "R1 low byte only");
        read_at(15'h5A01, "R1 high bits");
    endtask

    task automatic t_register_hold();
        read_at(15'h0123, "R2 setup");
        addr = 15'h4321;
        #1;
        check("R2 no change before edge", dq, exp_word(15'h0123));
        @(negedge clk);
        check("R2 new word after edge", dq, exp_word(15'h4321));
    endtask

    task automatic t_latch();
        read_at(15'h2AAA, "R7 setup");
        ale = INACT;
        #1;
        addr = 15'h1555;
        @(negedge clk);
        if (LATCH_ON)
            check("R7 R8 held address", dq, exp_word(15'h2AAA));
        else
            check("R6 ale ignored", dq, exp_word(15'h1555));
        addr = 15'h0777;
        @(negedge clk);
        if (LATCH_ON)
            check("R7 still held", dq, exp_word(15'h2AAA));
        else
            check("R6 flow-through", dq, exp_word(15'h0777));
        ale = ACT;
        @(negedge clk);
        check("R8 reopen at active level", dq, exp_word(15'h0777));
    endtask

    task automatic t_enable();
        read_at(15'h3C3C, "R4 R5 setup");
        oe_n = 1'b1;
        #1;
        check(SYNC_OE ? "R5 no change before edge" : "R4 immediate disable",
              {7'd0, dq_oe}, SYNC_OE ? 8'd1 : 8'd0);
        @(negedge clk);
        check("R4 R5 disabled after edge", {7'd0, dq_oe}, 8'd0);
        oe_n = 1'b0;
        #1;
        check(SYNC_OE ? "R5 no enable before edge" : "R4 immediate enable",
              {7'd0, dq_oe}, SYNC_OE ? 8'd0 : 8'd1);
        @(negedge clk);
        check("R4 R5 enabled after edge", {7'd0, dq_oe}, 8'd1);
        check("R4 R5 data after re-enable", dq, exp_word(15'h3C3C));
    endtask

    initial begin
        n_chk  = 0;
        n_fail = 0;
        done   = 1'b0;
        addr   = '0;
        ale    = ACT;
        oe_n   = 1'b0;
        t_reset();
        t_reads();
        t_register_hold();
        t_latch();
        t_enable();
        done = 1'b1;
    end
endmodule

// File: tb/rom_read_port_tb.sv
// Top bench: runs every combination of the three build-time options.
module rom_read_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   chk  [8];
    int   fail [8];
    logic [7:0] done;

    always #2 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_cfg
        localparam bit S = (i % 2) == 1;
        localparam bit L = ((i / 2) % 2) == 1;
        localparam bit H = ((i / 4) % 2) == 1;
        rom_cfg_bench #(.SYNC_OE(S), .LATCH_ON(L), .ALE_HIGH(H)) u_bench (
            .clk   (clk),
            .rst_n (rst_n),
            .n_chk (chk[i]),
            .n_fail(fail[i]),
            .done  (done[i])
        );
    end

    initial begin
        int total_chk;
        int total_fail;
        total_chk  = 0;
        total_fail = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 20000 && !(&done); c++) @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) begin
            total_chk  += chk[i];
            total_fail += fail[i];
        end
        if (!(&done)) begin
            total_chk++;
            total_fail++;
            $display("FAIL watchdog: scenarios unfinished, done=%b expected=%b", done, 8'hFF);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", total_chk, total_fail);
        $finish;
    end
endmodule